// File: doc/BRIEF.md
# Hysteretic Window Comparator With Alert

This block watches a stream of ADC conversion results, each tagged with the channel it came from. Every channel has its own high threshold, low threshold and hysteresis width. A high-side comparator trips when a result lies above the high threshold and lets go only once a result drops below the threshold less the hysteresis. A low-side comparator mirrors this below the low threshold. While a comparator stays tripped, a per-path debounce counter counts the channel's conversions. After a programmed number of consecutive tripped conversions, the matching sticky flag is set.

Software reads the sticky high and low flags directly. It clears them through a write strobe that selects a bank and carries a one-hot clear mask, so only the bits written as 1 are cleared. The alert output follows the flags of the channels that are enabled. A global enable and per-channel enables decide which conversions take part at all.

Top module: `win_alert_top`

## Requirements
- R1: The high comparator of a channel trips when a qualified conversion of that channel is strictly greater than the channel's high threshold. A result equal to the threshold does not trip it.
- R2: A tripped high comparator is released only by a result strictly below (high threshold − hysteresis), and it holds its state for results in between. The bound saturates at 0, so a hysteresis larger than the threshold means the comparator is never released.
- R3: The low comparator trips on a result strictly below the low threshold. It is released only by a result strictly above (low threshold + hysteresis), and it holds in between. The bound saturates at 4095.
- R4: With maximum event count M (8 bits, shared by all channels), a flag is set on the (M+1)-th consecutive qualified conversion of that channel with its comparator tripped. With M = 0 the first tripped conversion sets it. The flag is visible on the clock edge that samples that conversion.
- R5: A conversion that releases a comparator clears that path's counter, so the earlier tripped conversions no longer count.
- R6: Thresholds, hysteresis, comparator state and counters are kept per channel (2 channels, 12-bit results). Conversions of one channel do not touch the other channel's state.
- R7: A conversion taken while the global enable is 0, or while the channel's enable bit is 0, changes no comparator, counter or flag.
- R8: A clear write with `clr_sel` = 1 clears the high flags at the bit positions where `clr_data` is 1. With `clr_sel` = 0 it clears the low flags in the same way. Bits written 0 leave their flags unchanged.
- R9: If a flag is set by a conversion and cleared by a write in the same cycle, the flag stays set.
- R10: `alert` is 1 exactly while the global enable is 1 and some channel whose enable bit is 1 has a high or low flag set.
- R11: A synchronous active-high reset clears all comparators, counters and flags and drives `alert` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blk_en | input | 1 | Global comparator enable |
| cfg_ch_en | input | 2 | Per-channel enable, bit i for channel i |
| cfg_hi_thr | input | 24 | High thresholds, channel i at bits [12i+11:12i] |
| cfg_lo_thr | input | 24 | Low thresholds, channel i at bits [12i+11:12i] |
| cfg_hyst | input | 24 | Hysteresis, channel i at bits [12i+11:12i] |
| cfg_max_evt | input | 8 | Shared maximum event count M |
| cnv_valid | input | 1 | New conversion result strobe |
| cnv_ch | input | 1 | Channel of the conversion |
| cnv_data | input | 12 | Unsigned conversion result |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_sel | input | 1 | Bank selected by the clear write: 1 high, 0 low |
| clr_data | input | 2 | Clear mask, 1 clears the flag of channel i |
| flag_hi | output | 2 | Sticky high flags |
| flag_lo | output | 2 | Sticky low flags |
| alert | output | 1 | Alert output |

## Verification
Some rules are checked on every cycle by properties. A flag may rise only on a set event from its comparator path. It may fall only on a matching clear write. A set must survive a clash with a clear. Disabled channels never raise set events. `alert` never stands without a flag behind it, and reset empties the flags. The threshold arithmetic and the hysteresis hold region can only be shown by the directed scenarios: exact-threshold values, band-edge values, the saturated bounds, debounce runs broken by a release, and interleaved channels. Those scenarios also show that disabled conversions leave no trace in later comparator decisions.

// File: rtl/win_alert_pkg.sv
package win_alert_pkg;

  // Bank selector carried by a clear write
  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } flag_bank_e;

endpackage

// File: rtl/win_cmp_path.sv
// One comparator direction of one channel, with its debounce counter.
module win_cmp_path #(
  parameter int DW        = 12,
  parameter int CW        = 8,
  parameter bit HIGH_SIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] thr,
  input  logic [DW-1:0] hyst,
  input  logic [CW-1:0] max_evt,
  output logic          cmp_q,
  output logic          fire
);

  // threshold minus hysteresis, clamped at zero
  function automatic logic [DW-1:0] floor_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a < b) ? '0 : a - b;
  endfunction

  // threshold plus hysteresis, clamped at full scale
  function automatic logic [DW-1:0] ceil_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW] ? {DW{1'b1}} : s[DW-1:0];
  endfunction

  logic          trip;
  logic          release_hit;
  logic          cmp_nxt;
  logic [CW-1:0] cnt_q;

  generate
    if (HIGH_SIDE) begin : g_high
      always_comb begin
        trip        = data > thr;
        release_hit = data < floor_sub(thr, hyst);
      end
    end else begin : g_low
      always_comb begin
        trip        = data < thr;
        release_hit = data > ceil_add(thr, hyst);
      end
    end
  endgenerate

  always_comb begin
    if (trip)             cmp_nxt = 1'b1;
    else if (release_hit) cmp_nxt = 1'b0;
    else                  cmp_nxt = cmp_q;
  end

  assign fire = upd && cmp_nxt && (cnt_q >= max_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      cmp_q <= cmp_nxt;
      if (!cmp_nxt)              cnt_q <= '0;
      else if (cnt_q < max_evt)  cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/win_flag_bank.sv
// Sticky flags: hardware set, software write-one-to-clear, set wins.
module win_flag_bank #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] flag_q
);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/win_alert_top.sv
module win_alert_top
  import win_alert_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 12,
  parameter int CW     = 8,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_blk_en,
  input  logic [NUM_CH-1:0]    cfg_ch_en,
  input  logic [NUM_CH*DW-1:0] cfg_hi_thr,
  input  logic [NUM_CH*DW-1:0] cfg_lo_thr,
  input  logic [NUM_CH*DW-1:0] cfg_hyst,
  input  logic [CW-1:0]        cfg_max_evt,
  input  logic                 cnv_valid,
  input  logic [CHW-1:0]       cnv_ch,
  input  logic [DW-1:0]        cnv_data,
  input  logic                 clr_wr,
  input  logic                 clr_sel,
  input  logic [NUM_CH-1:0]    clr_data,
  output logic [NUM_CH-1:0]    flag_hi,
  output logic [NUM_CH-1:0]    flag_lo,
  output logic                 alert
);

  // internal events, named for the checker
  logic [NUM_CH-1:0] upd_ch;
  logic [NUM_CH-1:0] set_hi;
  logic [NUM_CH-1:0] set_lo;
  logic [NUM_CH-1:0] cmp_hi;
  logic [NUM_CH-1:0] cmp_lo;
  logic [NUM_CH-1:0] clr_hi_vec;
  logic [NUM_CH-1:0] clr_lo_vec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      assign upd_ch[gi] = cnv_valid && cfg_blk_en && cfg_ch_en[gi] && (cnv_ch == CHW'(gi));

      win_cmp_path #(.DW(DW), .CW(CW), .HIGH_SIDE(1'b1)) u_hi (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd_ch[gi]),
        .data    (cnv_data),
        .thr     (cfg_hi_thr[gi*DW +: DW]),
        .hyst    (cfg_hyst[gi*DW +: DW]),
        .max_evt (cfg_max_evt),
        .cmp_q   (cmp_hi[gi]),
        .fire    (set_hi[gi])
      );

      win_cmp_path #(.DW(DW), .CW(CW), .HIGH_SIDE(1'b0)) u_lo (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd_ch[gi]),
        .data    (cnv_data),
        .thr     (cfg_lo_thr[gi*DW +: DW]),
        .hyst    (cfg_hyst[gi*DW +: DW]),
        .max_evt (cfg_max_evt),
        .cmp_q   (cmp_lo[gi]),
        .fire    (set_lo[gi])
      );
    end
  endgenerate

  assign clr_hi_vec = (clr_wr && (flag_bank_e'(clr_sel) == BANK_HI)) ? clr_data : '0;
  assign clr_lo_vec = (clr_wr && (flag_bank_e'(clr_sel) == BANK_LO)) ? clr_data : '0;

  win_flag_bank #(.NUM_CH(NUM_CH)) u_bank_hi (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_hi),
    .clr_vec (clr_hi_vec),
    .flag_q  (flag_hi)
  );

  win_flag_bank #(.NUM_CH(NUM_CH)) u_bank_lo (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_lo),
    .clr_vec (clr_lo_vec),
    .flag_q  (flag_lo)
  );

  assign alert = cfg_blk_en && (|((flag_hi | flag_lo) & cfg_ch_en));

endmodule

// File: rtl/win_alert_chk.sv
module win_alert_chk #(
  parameter int NUM_CH = 2,
  parameter int CHW    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_blk_en,
  input logic [NUM_CH-1:0] cfg_ch_en,
  input logic              cnv_valid,
  input logic [CHW-1:0]    cnv_ch,
  input logic              clr_wr,
  input logic              clr_sel,
  input logic [NUM_CH-1:0] clr_data,
  input logic [NUM_CH-1:0] set_hi,
  input logic [NUM_CH-1:0] set_lo,
  input logic [NUM_CH-1:0] flag_hi,
  input logic [NUM_CH-1:0] flag_lo,
  input logic              alert
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_c
      // R4
      hi_rise_needs_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_hi[gi]) |-> $past(set_hi[gi]));
      // R4
      lo_rise_needs_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_lo[gi]) |-> $past(set_lo[gi]));
      // R8
      hi_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_hi[gi]) |-> $past(clr_wr && clr_sel && clr_data[gi]));
      // R8
      lo_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_lo[gi]) |-> $past(clr_wr && !clr_sel && clr_data[gi]));
      // R9
      hi_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_hi[gi] |=> flag_hi[gi]);
      // R9
      lo_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_lo[gi] |=> flag_lo[gi]);
      // R7
      gated_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hi[gi] || set_lo[gi]) |->
          (cnv_valid && cfg_blk_en && cfg_ch_en[gi] && cnv_ch == CHW'(gi)));
    end
  endgenerate

  // R10
  alert_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    alert |-> (|(flag_hi | flag_lo)));

  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (flag_hi == '0 && flag_lo == '0 && !alert));

endmodule

bind win_alert_top win_alert_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_blk_en (cfg_blk_en),
  .cfg_ch_en  (cfg_ch_en),
  .cnv_valid  (cnv_valid),
  .cnv_ch     (cnv_ch),
  .clr_wr     (clr_wr),
  .clr_sel    (clr_sel),
  .clr_data   (clr_data),
  .set_hi     (set_hi),
  .set_lo     (set_lo),
  .flag_hi    (flag_hi),
  .flag_lo    (flag_lo),
  .alert      (alert)
);

// File: tb/win_alert_top_bench.sv
module win_alert_top_bench;

  localparam int NUM_CH = 2;
  localparam int DW     = 12;
  localparam int CW     = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 cfg_blk_en = 1'b1;
  logic [NUM_CH-1:0]    cfg_ch_en = '1;
  logic [NUM_CH*DW-1:0] cfg_hi_thr = '0;
  logic [NUM_CH*DW-1:0] cfg_lo_thr = '0;
  logic [NUM_CH*DW-1:0] cfg_hyst = '0;
  logic [CW-1:0]        cfg_max_evt = '0;
  logic                 cnv_valid = 1'b0;
  logic [0:0]           cnv_ch = '0;
  logic [DW-1:0]        cnv_data = '0;
  logic                 clr_wr = 1'b0;
  logic                 clr_sel = 1'b0;
  logic [NUM_CH-1:0]    clr_data = '0;
  logic [NUM_CH-1:0]    flag_hi;
  logic [NUM_CH-1:0]    flag_lo;
  logic                 alert;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  win_alert_top u_win_alert_top (
    .clk(clk), .rst(rst), .cfg_blk_en(cfg_blk_en), .cfg_ch_en(cfg_ch_en),
    .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .cfg_hyst(cfg_hyst),
    .cfg_max_evt(cfg_max_evt), .cnv_valid(cnv_valid), .cnv_ch(cnv_ch),
    .cnv_data(cnv_data), .clr_wr(clr_wr), .clr_sel(clr_sel), .clr_data(clr_data),
    .flag_hi(flag_hi), .flag_lo(flag_lo), .alert(alert)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ch(input int ch, input int hi, input int lo, input int hy);
    cfg_hi_thr[ch*DW +: DW] = DW'(hi);
    cfg_lo_thr[ch*DW +: DW] = DW'(lo);
    cfg_hyst[ch*DW +: DW]   = DW'(hy);
  endtask

  // one conversion; results are visible at the following negedge
  task automatic conv(input int ch, input int d);
    @(negedge clk);
    cnv_valid = 1'b1; cnv_ch = 1'(ch); cnv_data = DW'(d);
    @(negedge clk);
    cnv_valid = 1'b0;
  endtask

  task automatic clr(input bit bank_hi, input int mask);
    @(negedge clk);
    clr_wr = 1'b1; clr_sel = bank_hi; clr_data = NUM_CH'(mask);
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    conv(1, 4000);
    do_reset();
    chk("R11 flag_hi after reset", int'(flag_hi), 0);
    chk("R11 flag_lo after reset", int'(flag_lo), 0);
    chk("R11 alert after reset", int'(alert), 0);
  endtask

  task automatic t_high_edge();
    conv(0, 3000);
    chk("R1 equal to high threshold", int'(flag_hi[0]), 0);
    conv(0, 3001);
    chk("R1 above high threshold", int'(flag_hi[0]), 1);
    chk("R10 alert with flag", int'(alert), 1);
  endtask

  task automatic t_high_hyst();
    clr(1, 1);
    conv(0, 2900);
    chk("R2 at band edge holds", int'(flag_hi[0]), 1);
    clr(1, 1);
    conv(0, 2899);
    chk("R2 below band releases", int'(flag_hi[0]), 0);
    conv(0, 2950);
    chk("R2 inside band stays released", int'(flag_hi[0]), 0);
    chk("R10 alert clears", int'(alert), 0);
  endtask

  task automatic t_low();
    conv(0, 1000);
    chk("R3 equal to low threshold", int'(flag_lo[0]), 0);
    conv(0, 999);
    chk("R3 below low threshold", int'(flag_lo[0]), 1);
    clr(0, 1);
    conv(0, 1100);
    chk("R3 at band edge holds", int'(flag_lo[0]), 1);
    clr(0, 1);
    conv(0, 1101);
    chk("R3 above band releases", int'(flag_lo[0]), 0);
    conv(0, 1050);
    chk("R3 inside band stays released", int'(flag_lo[0]), 0);
  endtask

  task automatic t_debounce();
    cfg_max_evt = 8'd2;
    conv(0, 3500); conv(0, 3500);
    chk("R4 two of three events", int'(flag_hi[0]), 0);
    conv(0, 2000);
    conv(0, 3500); conv(0, 3500);
    chk("R5 run broken by release", int'(flag_hi[0]), 0);
    conv(0, 3500);
    chk("R4 third consecutive event", int'(flag_hi[0]), 1);
    conv(0, 2000);
    clr(1, 1);
  endtask

  task automatic t_channels();
    cfg_max_evt = 8'd1;
    conv(0, 3500);
    conv(1, 2500);
    conv(1, 2500);
    chk("R6 ch1 own threshold and count", int'(flag_hi[1]), 1);
    chk("R6 ch0 count not advanced by ch1", int'(flag_hi[0]), 0);
    conv(0, 3500);
    chk("R6 ch0 second event", int'(flag_hi[0]), 1);
    conv(0, 2000); conv(1, 1000);
    clr(1, 3);
    cfg_max_evt = 8'd0;
  endtask

  task automatic t_enable();
    @(negedge clk); cfg_blk_en = 1'b0;
    conv(0, 4000);
    chk("R7 global disable no flag", int'(flag_hi[0]), 0);
    @(negedge clk); cfg_blk_en = 1'b1;
    conv(0, 2950);
    chk("R7 disabled conversion left comparator", int'(flag_hi[0]), 0);
    @(negedge clk); cfg_ch_en = 2'b01;
    conv(1, 3000);
    chk("R7 channel disable no flag", int'(flag_hi[1]), 0);
    @(negedge clk); cfg_ch_en = 2'b11;
    conv(1, 1990);
    chk("R7 channel disabled left comparator", int'(flag_hi[1]), 0);
    conv(1, 2500);
    chk("R10 alert ch1 enabled", int'(alert), 1);
    @(negedge clk); cfg_ch_en = 2'b01;
    #1 chk("R10 alert masked by channel enable", int'(alert), 0);
    chk("R10 flag kept while masked", int'(flag_hi[1]), 1);
    cfg_blk_en = 1'b0; cfg_ch_en = 2'b11;
    #1 chk("R10 alert masked by global enable", int'(alert), 0);
    cfg_blk_en = 1'b1;
    #1 chk("R10 alert back", int'(alert), 1);
    conv(1, 1000);
    clr(1, 2);
  endtask

  task automatic t_w1c();
    conv(0, 500);
    conv(1, 2500);
    clr(1, 1);
    chk("R8 hi clear of other bit", int'(flag_hi[1]), 1);
    chk("R8 hi clear leaves lo bank", int'(flag_lo[0]), 1);
    clr(0, 2);
    chk("R8 lo clear of other bit", int'(flag_lo[0]), 1);
    clr(1, 0);
    chk("R8 zero write no effect", int'(flag_hi[1]), 1);
    clr(0, 1);
    chk("R8 lo clear bit0", int'(flag_lo[0]), 0);
    chk("R8 hi unaffected by lo clear", int'(flag_hi[1]), 1);
    clr(1, 2);
    chk("R8 hi clear bit1", int'(flag_hi[1]), 0);
    chk("R10 alert after all clears", int'(alert), 0);
    conv(0, 2000); conv(1, 1000);
  endtask

  task automatic t_set_wins();
    conv(0, 3500);
    @(negedge clk);
    cnv_valid = 1'b1; cnv_ch = 1'b0; cnv_data = 12'd3500;
    clr_wr = 1'b1; clr_sel = 1'b1; clr_data = 2'b01;
    @(negedge clk);
    cnv_valid = 1'b0; clr_wr = 1'b0; clr_data = '0;
    chk("R9 set beats clear", int'(flag_hi[0]), 1);
    clr(1, 1);
    chk("R9 plain clear afterwards", int'(flag_hi[0]), 0);
    conv(0, 2000);
  endtask

  task automatic t_saturate();
    set_ch(1, 5, 4090, 10);
    conv(1, 6);
    clr(1, 2); clr(0, 2);
    conv(1, 0);
    chk("R2 bound clamps at zero", int'(flag_hi[1]), 1);
    clr(1, 2); clr(0, 2);
    conv(1, 4095);
    chk("R3 bound clamps at full scale", int'(flag_lo[1]), 1);
  endtask

  initial begin
    set_ch(0, 3000, 1000, 100);
    set_ch(1, 2000, 500, 50);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high_edge();
    t_high_hyst();
    t_low();
    t_debounce();
    t_channels();
    t_enable();
    t_w1c();
    t_set_wins();
    t_saturate();
    do_reset();
    chk("R11 flags cleared mid-run", int'(flag_hi | flag_lo), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule